// File: doc/BRIEF.md
# System Management Interrupt Entry Sequencer

This block carries a processor core from normal execution into a system management interrupt handler. The request arrives as a level on an input pin. Once the block sees the request in its idle state, it commits to the entry and holds off the dispatch of new instructions. It then waits until the count of instructions still in flight reaches zero, so that any exception those instructions raise is taken before this one.

When the pipeline is empty, the block captures two values in a single cycle. The first save register holds the address of the instruction that would have run next. The second holds a masked copy of the machine state word. In the same cycle the block forms the replacement machine state word and the fetch redirect address. On the following cycle it raises a one-cycle strobe. The core uses that strobe both to load the new machine state and to restart fetch at the redirect address.

A lower-priority external interrupt shares the same sequencer. It is only accepted when its enable bit is set, and it goes to its own vector offset. The vector base depends on a single prefix bit of the machine state: when the bit is clear the base is zero, and when it is set the base is a high address.

Top module: `intr_entry_seq`

## Requirements
Machine state bit indices below count from the least significant bit (bit 0). The fields are: LE=0, RI=1, PM=2, DR=4, IR=5, IP=6, FE1=8, BE=9, SE=10, FE0=11, ME=12, FP=13, PR=14, EE=15, ILE=16, POW=18, VEC=25.
- R1: After reset, `dispatchHold` and `redirectValid` are 0, and `srr0`, `srr1`, `msrNew` and `redirectAddr` are all zero.
- R2: A request seen while idle raises `dispatchHold` on the next cycle. `dispatchHold` then stays high up to and including the strobe cycle, and is low on the cycle after the strobe.
- R3: Entry waits while `pendCount` is nonzero. `redirectValid` rises exactly two cycles after the first cycle in the drain phase that samples `pendCount` as zero.
- R4: At the strobe, `srr0` equals `nextPc` as sampled in the cycle before the strobe.
- R5: At the strobe, `srr1` equals the sampled machine state ANDed with 0x0200FFFF. That is, bit 25 and bits 15..0 are copied and every other bit is zero.
- R6: At the strobe, `msrNew` has bit 0 equal to the old ILE (bit 16). The bits in 0x0204EF76 are cleared. All other bits, including ILE and ME, keep their old values.
- R7: A system management entry redirects to base | 0x1400. The base is 0xFFF00000 when the old IP bit (bit 6) is 1, and 0 when it is 0.
- R8: When both requests are present in the same idle cycle, the system management request is taken.
- R9: An external request is accepted only when EE (bit 15) is 1, and it redirects to base | 0x0500. A system management request is accepted whatever the value of EE.
- R10: An external request that arrives while a system management entry is draining does not change that entry. It is taken afterwards, once the sequencer is idle again, if it is still asserted.
- R11: Once entry has begun, dropping the request does not cancel it. A request still high when the sequencer is back in idle starts a new entry, with `dispatchHold` rising on the second cycle after the strobe.
- R12: `redirectValid` is high for exactly one cycle per entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| smReq | input | 1 | System management request, level |
| extReq | input | 1 | External interrupt request, level |
| pendCount | input | PEND_W | Instructions still in flight |
| nextPc | input | ADDR_W | Address of the next instruction to execute |
| msrIn | input | 32 | Current machine state word |
| dispatchHold | output | 1 | Stop dispatching new instructions |
| redirectValid | output | 1 | One-cycle strobe: load msrNew and redirect fetch |
| redirectAddr | output | ADDR_W | Fetch redirect address |
| srr0 | output | ADDR_W | Saved resume address |
| srr1 | output | 32 | Saved masked machine state |
| msrNew | output | 32 | Machine state to load at entry |

## Verification
The bench builds the block with `PEND_W` = 3, so a drain of every length from zero to the full count of 7 can be reached within a few cycles. This makes it cheap to check the exact strobe latency at both ends of the range. The address width and vector constants keep their default values, so the bench sees the real 0x1400 and 0x0500 offsets under both settings of the prefix bit. Random machine state words exercise every masked and copied bit of both save values.

// File: rtl/intr_entry_pkg.sv
package intr_entry_pkg;

  typedef enum logic [1:0] {
    ST_IDLE     = 2'd0,
    ST_DRAIN    = 2'd1,
    ST_SAVE     = 2'd2,
    ST_REDIRECT = 2'd3
  } seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;
    logic selSmi;
  } entryStb_t;

  // machine state bit positions, LSB = 0
  localparam int MSR_LE  = 0;
  localparam int MSR_IP  = 6;
  localparam int MSR_EE  = 15;
  localparam int MSR_ILE = 16;

  // bits copied into the second save register
  localparam logic [31:0] SAVE_KEEP = 32'h0200_FFFF;
  // bits forced to zero in the new machine state (LE handled apart)
  localparam logic [31:0] ENTRY_CLR = 32'h0204_EF76;

endpackage

// File: rtl/intr_entry_ctrl.sv
module intr_entry_ctrl
  import intr_entry_pkg::*;
#(
  parameter int PEND_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              smReq,
  input  logic              extReq,
  input  logic              extEnable,
  input  logic [PEND_W-1:0] pendCount,
  output entryStb_t         stb,
  output logic              dispatchHold,
  output logic              redirectValid
);

  seqState_t state, stateNext;
  logic      kindSmi, kindSmiNext;
  logic      drained;

  assign drained = (pendCount == '0);

  always_comb begin
    stateNext   = state;
    kindSmiNext = kindSmi;
    unique case (state)
      ST_IDLE: begin
        if (smReq) begin
          stateNext   = ST_DRAIN;
          kindSmiNext = 1'b1;
        end else if (extReq && extEnable) begin
          stateNext   = ST_DRAIN;
          kindSmiNext = 1'b0;
        end
      end
      ST_DRAIN:    if (drained) stateNext = ST_SAVE;
      ST_SAVE:     stateNext = ST_REDIRECT;
      ST_REDIRECT: stateNext = ST_IDLE;
      default:     stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      kindSmi <= 1'b0;
    end else begin
      state   <= stateNext;
      kindSmi <= kindSmiNext;
    end
  end

  assign stb.capture   = (state == ST_SAVE);
  assign stb.selSmi    = kindSmi;
  assign dispatchHold  = (state != ST_IDLE);
  assign redirectValid = (state == ST_REDIRECT);

endmodule

// File: rtl/intr_entry_dpath.sv
module intr_entry_dpath
  import intr_entry_pkg::*;
#(
  parameter int              ADDR_W     = 32,
  parameter logic [ADDR_W-1:0] SMI_OFFSET = 'h1400,
  parameter logic [ADDR_W-1:0] EXT_OFFSET = 'h0500,
  parameter logic [ADDR_W-1:0] HIGH_BASE  = 'hFFF0_0000
) (
  input  logic              clk,
  input  logic              rstN,
  input  entryStb_t         stb,
  input  logic [ADDR_W-1:0] nextPc,
  input  logic [31:0]       msrIn,
  output logic [ADDR_W-1:0] srr0,
  output logic [31:0]       srr1,
  output logic [31:0]       msrNew,
  output logic [ADDR_W-1:0] redirectAddr
);

  logic [ADDR_W-1:0] vecBase;
  logic [ADDR_W-1:0] vecOffset;
  logic [31:0]       msrEntry;

  assign vecBase   = msrIn[MSR_IP] ? HIGH_BASE : '0;
  assign vecOffset = stb.selSmi ? SMI_OFFSET : EXT_OFFSET;

  // clear the listed fields, then place ILE into LE
  always_comb begin
    msrEntry         = msrIn & ~ENTRY_CLR;
    msrEntry[MSR_LE] = msrIn[MSR_ILE];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      srr0         <= '0;
      srr1         <= '0;
      msrNew       <= '0;
      redirectAddr <= '0;
    end else if (stb.capture) begin
      srr0         <= nextPc;
      srr1         <= msrIn & SAVE_KEEP;
      msrNew       <= msrEntry;
      redirectAddr <= vecBase | vecOffset;
    end
  end

endmodule

// File: rtl/intr_entry_seq.sv
module intr_entry_seq
  import intr_entry_pkg::*;
#(
  parameter int                ADDR_W     = 32,
  parameter int                PEND_W     = 4,
  parameter logic [ADDR_W-1:0] SMI_OFFSET = 'h1400,
  parameter logic [ADDR_W-1:0] EXT_OFFSET = 'h0500,
  parameter logic [ADDR_W-1:0] HIGH_BASE  = 'hFFF0_0000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              smReq,
  input  logic              extReq,
  input  logic [PEND_W-1:0] pendCount,
  input  logic [ADDR_W-1:0] nextPc,
  input  logic [31:0]       msrIn,
  output logic              dispatchHold,
  output logic              redirectValid,
  output logic [ADDR_W-1:0] redirectAddr,
  output logic [ADDR_W-1:0] srr0,
  output logic [31:0]       srr1,
  output logic [31:0]       msrNew
);

  entryStb_t stb;

  intr_entry_ctrl #(.PEND_W(PEND_W)) u_ctrl (
    .clk           (clk),
    .rstN          (rstN),
    .smReq         (smReq),
    .extReq        (extReq),
    .extEnable     (msrIn[MSR_EE]),
    .pendCount     (pendCount),
    .stb           (stb),
    .dispatchHold  (dispatchHold),
    .redirectValid (redirectValid)
  );

  intr_entry_dpath #(
    .ADDR_W     (ADDR_W),
    .SMI_OFFSET (SMI_OFFSET),
    .EXT_OFFSET (EXT_OFFSET),
    .HIGH_BASE  (HIGH_BASE)
  ) u_dpath (
    .clk          (clk),
    .rstN         (rstN),
    .stb          (stb),
    .nextPc       (nextPc),
    .msrIn        (msrIn),
    .srr0         (srr0),
    .srr1         (srr1),
    .msrNew       (msrNew),
    .redirectAddr (redirectAddr)
  );

endmodule

// File: rtl/intr_entry_chk.sv
module intr_entry_chk #(
  parameter int ADDR_W = 32,
  parameter int PEND_W = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              smReq,
  input logic              extReq,
  input logic [PEND_W-1:0] pendCount,
  input logic [ADDR_W-1:0] nextPc,
  input logic [31:0]       msrIn,
  input logic              dispatchHold,
  input logic              redirectValid,
  input logic [ADDR_W-1:0] srr0,
  input logic [31:0]       srr1,
  input logic [31:0]       msrNew
);

  p_strobe_single_r12: assert property (@(posedge clk) disable iff (!rstN)
    redirectValid |=> !redirectValid);

  p_hold_at_strobe_r2: assert property (@(posedge clk) disable iff (!rstN)
    redirectValid |-> dispatchHold);

  p_hold_drops_r2: assert property (@(posedge clk) disable iff (!rstN)
    redirectValid && !smReq && !extReq |=> !dispatchHold);

  p_hold_cause_r2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(dispatchHold) |-> $past(smReq) || $past(extReq));

  p_drain_done_r3: assert property (@(posedge clk) disable iff (!rstN)
    redirectValid |-> $past(pendCount, 2) == '0);

  p_srr0_r4: assert property (@(posedge clk) disable iff (!rstN)
    redirectValid |-> srr0 == $past(nextPc));

  p_srr1_mask_r5: assert property (@(posedge clk) disable iff (!rstN)
    redirectValid |-> srr1 == ($past(msrIn) & 32'h0200_FFFF));

  p_msr_le_r6: assert property (@(posedge clk) disable iff (!rstN)
    redirectValid |-> msrNew[0] == $past(msrIn[16]));

  p_msr_clear_r6: assert property (@(posedge clk) disable iff (!rstN)
    redirectValid |-> (msrNew & 32'h0204_EF76) == 32'h0);

  p_ext_gate_r9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(dispatchHold) && !$past(smReq) |-> $past(msrIn[15]));

endmodule

bind intr_entry_seq intr_entry_chk #(.ADDR_W(ADDR_W), .PEND_W(PEND_W)) u_chk (
  .clk           (clk),
  .rstN          (rstN),
  .smReq         (smReq),
  .extReq        (extReq),
  .pendCount     (pendCount),
  .nextPc        (nextPc),
  .msrIn         (msrIn),
  .dispatchHold  (dispatchHold),
  .redirectValid (redirectValid),
  .srr0          (srr0),
  .srr1          (srr1),
  .msrNew        (msrNew)
);

// File: tb/intr_entry_seq_tb.sv
module intr_entry_seq_tb;

  localparam int ADDR_W = 32;
  localparam int PEND_W = 3;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              smReq = 1'b0;
  logic              extReq = 1'b0;
  logic [PEND_W-1:0] pendCount = '0;
  logic [ADDR_W-1:0] nextPc = '0;
  logic [31:0]       msrIn = '0;
  logic              dispatchHold, redirectValid;
  logic [ADDR_W-1:0] redirectAddr, srr0;
  logic [31:0]       srr1, msrNew;

  int checkCnt = 0;
  int failCnt  = 0;

  always #2 clk = ~clk;  // 4 ns period

  intr_entry_seq #(.ADDR_W(ADDR_W), .PEND_W(PEND_W)) u_dut (
    .clk(clk), .rstN(rstN), .smReq(smReq), .extReq(extReq),
    .pendCount(pendCount), .nextPc(nextPc), .msrIn(msrIn),
    .dispatchHold(dispatchHold), .redirectValid(redirectValid),
    .redirectAddr(redirectAddr), .srr0(srr0), .srr1(srr1), .msrNew(msrNew)
  );

  function automatic logic [31:0] expSrr1(input logic [31:0] m);
    return m & 32'h0200_FFFF;
  endfunction

  function automatic logic [31:0] expMsr(input logic [31:0] m);
    logic [31:0] r;
    r    = m & ~32'h0204_EF77;
    r[0] = m[16];
    return r;
  endfunction

  function automatic logic [31:0] expAddr(input logic [31:0] m, input bit smi);
    return (m[6] ? 32'hFFF0_0000 : 32'h0) | (smi ? 32'h1400 : 32'h0500);
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    checkCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one complete entry; inputs are driven and outputs sampled on negedges
  task automatic runEntry(input bit useSmi, input logic [31:0] m,
                          input logic [31:0] pc, input int drain,
                          input bit dropEarly, input bit extStart,
                          input bit extMid, input bit keepSmi);
    int  n;
    int  expN;
    bit  holdOk;
    bit  seen;
    @(negedge clk);
    msrIn     = m;
    nextPc    = pc;
    pendCount = drain[PEND_W-1:0];
    if (useSmi) smReq = 1'b1; else extReq = 1'b1;
    if (extStart) extReq = 1'b1;
    n = 0; holdOk = 1'b1; seen = 1'b0;
    while (!seen && n < 40) begin
      @(negedge clk);
      n++;
      if (pendCount != '0) pendCount = pendCount - 1'b1;
      if (n == 1 && dropEarly) begin
        if (useSmi) smReq = 1'b0; else extReq = 1'b0;
      end
      if (n == 1 && extMid) extReq = 1'b1;
      if (!dispatchHold) holdOk = 1'b0;
      if (redirectValid) seen = 1'b1;
    end
    expN = ((drain + 1 > 2) ? drain + 1 : 2) + 1;
    check(seen && n == expN, "R3 strobe latency after drain", n, expN);
    check(holdOk, "R2 hold through drain", holdOk, 1);
    check(srr0 == pc, "R4 srr0", srr0, pc);
    check(srr1 == expSrr1(m), "R5 srr1 mask", srr1, expSrr1(m));
    check(msrNew == expMsr(m), "R6 new msr", msrNew, expMsr(m));
    check(redirectAddr == expAddr(m, useSmi),
          useSmi ? "R7 smi vector" : "R9 ext vector",
          redirectAddr, expAddr(m, useSmi));
    if (useSmi && !keepSmi) smReq = 1'b0;
    if (!useSmi || extStart) extReq = 1'b0;
    @(negedge clk);
    check(!redirectValid, "R12 strobe one cycle", redirectValid, 0);
    check(!dispatchHold, "R2 hold released", dispatchHold, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checkCnt++;
    failCnt++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
    $finish;
  end

  initial begin
    int n;
    bit any;
    logic [31:0] m;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(!dispatchHold && !redirectValid, "R1 reset control", {dispatchHold, redirectValid}, 0);
    check(srr0 == 0 && srr1 == 0, "R1 reset save regs", srr0 | srr1, 0);
    check(msrNew == 0 && redirectAddr == 0, "R1 reset msr/addr", msrNew | redirectAddr, 0);

    // directed corners: drain lengths zero and full, both prefix settings
    runEntry(1, 32'h0000_0040, 32'h0000_1000, 0, 0, 0, 0, 0);  // R7 high base
    runEntry(1, 32'hFFFF_FFBF, 32'hDEAD_BEE0, 7, 0, 0, 0, 0);  // R3 max drain
    runEntry(1, 32'h0001_0000, 32'h0000_2000, 1, 1, 0, 0, 0);  // R11 drop during drain, R6 ILE->LE
    runEntry(1, 32'h0000_0000, 32'h0000_3000, 2, 0, 0, 0, 0);  // R9 smi ignores EE=0

    // R8 both present together: smi wins
    runEntry(1, 32'h0000_8040, 32'h0000_4000, 3, 0, 1, 0, 0);

    // R9 ext with EE=0 must not start an entry
    @(negedge clk);
    msrIn = 32'h0000_0000;
    extReq = 1'b1;
    any = 1'b0;
    repeat (6) begin
      @(negedge clk);
      if (dispatchHold || redirectValid) any = 1'b1;
    end
    check(!any, "R9 ext blocked by EE=0", any, 0);
    extReq = 1'b0;

    // R10 ext arriving during smi drain stays pending, then taken
    runEntry(1, 32'h0000_8000, 32'h0000_5000, 4, 0, 0, 1, 0);
    n = 0;
    while (!redirectValid && n < 20) begin @(negedge clk); n++; end
    check(redirectAddr == expAddr(32'h0000_8000, 0), "R10 pending ext taken after",
          redirectAddr, expAddr(32'h0000_8000, 0));
    extReq = 1'b0;
    @(negedge clk);

    // R11 request held high re-arms after idle
    runEntry(1, 32'h0000_0000, 32'h0000_6000, 0, 0, 0, 0, 1);
    n = 1;
    while (!redirectValid && n < 20) begin @(negedge clk); n++; end
    smReq = 1'b0;
    check(n == 4, "R11 re-entry latency", n, 4);
    @(negedge clk);
    @(negedge clk);

    // constrained random entries
    for (int i = 0; i < 40; i++) begin
      bit smi;
      smi = $urandom_range(0, 1) == 1;
      m = $urandom();
      if (!smi) m[15] = 1'b1;
      runEntry(smi, m, $urandom(), $urandom_range(0, 7),
               $urandom_range(0, 1) == 1, 0, 0, 0);
    end

    $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
    $finish;
  end

endmodule